// File: doc/BRIEF.md
# Bidirectional Heat/Cool PWM Modulator

This block turns a signed digital demand word into the drive for a load that needs current in either direction, such as a thermoelectric element. It drives two outputs. The direction output stays at a static level: low for cooling and high for heating. The PWM output is the only one that switches. The filtered voltage between the two outputs then follows the demand. In cooling mode the load sees D times the supply, where D is the PWM duty cycle. In heating mode the duty is complemented, so the load sees minus (1 − D) times the supply. A larger heating demand therefore gives a lower duty cycle.

The switching period comes from one of two sources. The first is an internal ramp with a fast and a slow tick rate. The second is an external sync clock running at half the switching rate; the block doubles it by starting a new period on every edge. A hysteresis band around zero demand stops the direction from chattering. Inside that band an opposite-sign demand gives zero drive: both outputs low in cooling, both high in heating. The direction and the compare value are taken only at a period boundary. A shutdown input or a disable input idles the stage.

Top module: `hc_pwm_mod`

## Requirements
- R1: In cooling (dir_o low), pwm_o is high while the ramp value is below the latched magnitude. Each period of P = 2^(DMD_W-1) = 128 ticks therefore has exactly that many high ticks.
- R2: In heating (dir_o high), pwm_o is high while the ramp value is at or above the latched magnitude, giving P minus the magnitude high ticks per period.
- R3: The magnitude is the absolute value of the demand, taken as a two's-complement value. The most negative code, -128, is clamped to P-1 = 127.
- R4: The direction changes to heating when demand <= -HYST_TH and to cooling when demand >= +HYST_TH. Otherwise it holds. With HYST_TH = 8, a demand of -8 switches to heating and +7 does not switch back. A demand of the opposite sign to the held direction gives magnitude 0, so both outputs sit low in cooling or both sit high in heating.
- R5: Direction and magnitude are latched only at a period boundary. A demand change in mid-period never produces an extra pulse in that period.
- R6: With src_int_i high and rate_slow_i low, the ramp advances every clock, so a period is 128 clocks. With rate_slow_i high it advances every SLOW_DIV = 5 clocks, so a period is 640 clocks.
- R7: With src_int_i low, ext_sync_i passes through a two-flop synchronizer. Each of its edges, rising or falling, starts a new period. The ramp advances every clock and saturates at P-1, giving two periods per sync cycle.
- R8: When shdn_n_i is low or out_dis_i is high, out_en_o, pwm_o and dir_o are low. The ramp and the latched state are cleared to cooling with magnitude 0, so the first period after re-enable has zero duty.
- R9: While and after reset, the latched state is cooling with magnitude 0, so dir_o and pwm_o are low and out_en_o follows the enable inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| demand_i | input | 8 | Signed two's-complement drive demand |
| rate_slow_i | input | 1 | High selects the slow internal tick rate |
| src_int_i | input | 1 | High selects the internal timebase, low the external sync |
| ext_sync_i | input | 1 | External sync clock at half the switching rate |
| shdn_n_i | input | 1 | Low puts the stage in shutdown |
| out_dis_i | input | 1 | High disables the output stage |
| pwm_o | output | 1 | Switching output |
| dir_o | output | 1 | Static direction output, high for heating |
| out_en_o | output | 1 | Output-stage enable; low means both outputs are high impedance |

## Verification
High ticks are counted over a window of exactly one period, which gives the same count at any phase. Positive demands show the direct duty, negative demands the complemented duty, and -128 the clamp. A walk through values at and just inside plus and minus eight separates the switching thresholds from the hold band, and shows whether both outputs sit low or both sit high inside that band. The demand is raised right after a falling edge of pwm_o, which exposes any mid-period update. Separate windows cover the slow rate, counts of rising edges under external sync (to tell doubling from plain sync), and the shutdown and disable inputs including the zero-duty first period. Random demands run through a bench model that tracks the hysteresis state.

// File: rtl/hc_pkg.sv
package hc_pkg;
    localparam int DMD_W = 8;
    localparam int MAG_W = DMD_W - 1;

    typedef logic signed [DMD_W-1:0] demand_t;
    typedef logic [MAG_W-1:0]        mag_t;
    typedef enum logic {DIR_COOL = 1'b0, DIR_HEAT = 1'b1} dir_e;

    typedef struct packed {
        dir_e dir;
        mag_t mag;
    } drive_s;

    // direction after hysteresis: switch only beyond +/- h
    function automatic dir_e next_dir(demand_t d, dir_e cur, demand_t h);
        if (d <= -h)
            return DIR_HEAT;
        else if (d >= h)
            return DIR_COOL;
        else
            return cur;
    endfunction

    // magnitude for the chosen direction; opposite sign gives zero drive
    function automatic mag_t eff_mag(demand_t d, dir_e dir);
        logic [DMD_W-1:0] neg;
        neg = -d;
        if (d < 0) begin
            if (dir == DIR_COOL)
                return '0;
            else if (neg[DMD_W-1])
                return '1;
            else
                return neg[MAG_W-1:0];
        end else begin
            if (dir == DIR_HEAT)
                return '0;
            else
                return d[MAG_W-1:0];
        end
    endfunction
endpackage

// File: rtl/hc_timebase.sv
module hc_timebase
    import hc_pkg::*;
#(
    parameter int SLOW_DIV = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic rate_slow,
    input  logic src_int,
    input  logic ext_sync,
    output mag_t cnt,
    output logic bnd
);
    localparam int   PRE_W   = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam mag_t CNT_TOP = '1;

    logic [PRE_W-1:0] pre_q;
    logic [2:0]       sync_q;
    logic             tick;
    logic             sync_edge;

    assign tick      = rate_slow ? (pre_q == PRE_W'(SLOW_DIV - 1)) : 1'b1;
    assign sync_edge = sync_q[2] ^ sync_q[1];
    assign bnd       = run & (src_int ? (tick && cnt == CNT_TOP) : sync_edge);

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '0;
        else
            sync_q <= {sync_q[1:0], ext_sync};
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
            cnt   <= '0;
        end else if (src_int) begin
            if (tick) begin
                pre_q <= '0;
                cnt   <= cnt + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end else begin
            pre_q <= '0;
            if (sync_edge)
                cnt <= '0;
            else if (cnt != CNT_TOP)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hc_latch.sv
module hc_latch
    import hc_pkg::*;
#(
    parameter int HYST_TH = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    bnd,
    input  demand_t demand,
    output drive_s  drv
);
    localparam demand_t HYST_V = demand_t'(HYST_TH);

    dir_e dir_n;

    always_comb dir_n = next_dir(demand, drv.dir, HYST_V);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            drv.dir <= DIR_COOL;
            drv.mag <= '0;
        end else if (bnd) begin
            drv.dir <= dir_n;
            drv.mag <= eff_mag(demand, dir_n);
        end
    end
endmodule

// File: rtl/hc_pwm_mod.sv
module hc_pwm_mod
    import hc_pkg::*;
#(
    parameter int HYST_TH  = 8,
    parameter int SLOW_DIV = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [DMD_W-1:0] demand_i,
    input  logic                    rate_slow_i,
    input  logic                    src_int_i,
    input  logic                    ext_sync_i,
    input  logic                    shdn_n_i,
    input  logic                    out_dis_i,
    output logic                    pwm_o,
    output logic                    dir_o,
    output logic                    out_en_o
);
    logic   run;
    logic   bnd;
    logic   cmp;
    mag_t   cnt;
    drive_s drv_q;

    assign run = shdn_n_i & ~out_dis_i;

    hc_timebase #(.SLOW_DIV(SLOW_DIV)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .rate_slow (rate_slow_i),
        .src_int   (src_int_i),
        .ext_sync  (ext_sync_i),
        .cnt       (cnt),
        .bnd       (bnd)
    );

    hc_latch #(.HYST_TH(HYST_TH)) u_lat (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .bnd    (bnd),
        .demand (demand_i),
        .drv    (drv_q)
    );

    // heating complements the duty: high for the remainder of the period
    assign cmp      = (drv_q.dir == DIR_HEAT) ? (cnt >= drv_q.mag) : (cnt < drv_q.mag);
    assign pwm_o    = run & cmp;
    assign dir_o    = run & (drv_q.dir == DIR_HEAT);
    assign out_en_o = run;
endmodule

// File: rtl/hc_pwm_chk.sv
module hc_pwm_chk
    import hc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       shdn_n,
    input logic       out_dis,
    input logic       pwm,
    input logic       dir,
    input logic       out_en,
    input logic       bnd,
    input logic [MAG_W-1:0] cnt,
    input logic       lat_dir,
    input logic [MAG_W-1:0] lat_mag
);
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!shdn_n || out_dis) |-> (!out_en && !pwm && !dir)); // R8

    AST_HEAT_FLAT: assert property (@(posedge clk) disable iff (rst)
        (out_en && lat_dir && lat_mag == '0) |-> pwm); // R4

    AST_COOL_FLAT: assert property (@(posedge clk) disable iff (rst)
        (out_en && !lat_dir && lat_mag == '0) |-> !pwm); // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_en && $past(out_en) && !$past(bnd)) |-> ($stable(lat_dir) && $stable(lat_mag))); // R5

    AST_BOUND_ZERO: assert property (@(posedge clk) disable iff (rst)
        bnd |=> (cnt == '0)); // R7
endmodule

bind hc_pwm_mod hc_pwm_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .shdn_n  (shdn_n_i),
    .out_dis (out_dis_i),
    .pwm     (pwm_o),
    .dir     (dir_o),
    .out_en  (out_en_o),
    .bnd     (bnd),
    .cnt     (cnt),
    .lat_dir (drv_q.dir),
    .lat_mag (drv_q.mag)
);

// File: tb/test_hc_pwm_mod.sv
`timescale 1ns/1ps
module test_hc_pwm_mod;
    import hc_pkg::*;

    localparam int P    = 128;
    localparam int HYST = 8;
    localparam int SDIV = 5;
    localparam int TEXT = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [DMD_W-1:0] demand = '0;
    logic rate_slow = 1'b0, src_int = 1'b1, ext_sync = 1'b0;
    logic shdn_n = 1'b1, out_dis = 1'b0;
    logic pwm, dir, out_en;
    logic ext_run = 1'b0;
    bit   done = 1'b0;

    int checks = 0;
    int failures = 0;
    int m_dir = 0;

    always #2 clk = ~clk;

    hc_pwm_mod i_hc_pwm_mod (
        .clk(clk), .rst(rst), .demand_i(demand), .rate_slow_i(rate_slow),
        .src_int_i(src_int), .ext_sync_i(ext_sync), .shdn_n_i(shdn_n),
        .out_dis_i(out_dis), .pwm_o(pwm), .dir_o(dir), .out_en_o(out_en)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (ext_run) begin
                repeat (TEXT - 1) @(negedge clk);
                ext_sync = ~ext_sync;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n, output int hi, output int rises);
        logic prev;
        hi = 0; rises = 0;
        prev = pwm;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm) hi++;
            if (pwm && !prev) rises++;
            prev = pwm;
        end
    endtask

    // bench model of direction, magnitude and high ticks per period
    function automatic int model_hi(input int d);
        int mag;
        if (d <= -HYST) m_dir = 1;
        else if (d >= HYST) m_dir = 0;
        if (d < 0) mag = (m_dir == 1) ? ((d == -128) ? 127 : -d) : 0;
        else       mag = (m_dir == 0) ? d : 0;
        return (m_dir == 1) ? (P - mag) : mag;
    endfunction

    task automatic step(input int d, input int exp_dir, input int exp_hi, input string tag);
        int hi, r;
        demand = DMD_W'(d);
        wait_clk(3 * P);
        measure(P, hi, r);
        check({tag, " dir"}, int'(dir), exp_dir);
        check({tag, " high ticks"}, hi, exp_hi);
    endtask

    initial begin
        int hi, r, lows, guard, e, rv;
        logic prev;
        rv = $urandom(32'd1234);
        wait_clk(3);
        check("R9 reset dir", int'(dir), 0);
        check("R9 reset pwm", int'(pwm), 0);
        check("R9 reset out_en", int'(out_en), 1);
        rst = 1'b0;
        wait_clk(2);

        step(5,    0, 5,   "R1 cool +5");
        step(-5,   0, 0,   "R4 hold band cool both low");
        step(-20,  1, 108, "R2 heat -20");
        step(5,    1, 128, "R4 hold band heat both high");
        step(30,   0, 30,  "R4 switch cool +30");
        step(-8,   1, 120, "R4 threshold -8");
        step(7,    1, 128, "R4 hold at +7");
        step(8,    0, 8,   "R4 threshold +8");
        step(-128, 1, 1,   "R3 clamp -128");
        step(127,  0, 127, "R1 full +127");

        // R5: raise demand right after a falling edge; no new pulse this period
        step(10, 0, 10, "R5 setup");
        prev = pwm; guard = 0;
        do begin
            prev = pwm;
            @(negedge clk);
            guard++;
        end while (!(prev && !pwm) && guard < 4 * P);
        demand = 8'sd100;
        lows = 1;
        guard = 0;
        while (1) begin
            @(negedge clk);
            if (pwm || guard > 4 * P) break;
            lows++; guard++;
        end
        check("R5 low run after mid-period change", lows, 118);
        measure(P, hi, r);
        check("R5 next period uses new value", hi, 100);

        // R6 slow rate
        rate_slow = 1'b1;
        demand = 8'sd50;
        wait_clk(3 * P * SDIV);
        measure(P * SDIV, hi, r);
        check("R6 slow rate high ticks", hi, 50 * SDIV);
        rate_slow = 1'b0;

        // R7 external sync with doubling
        src_int = 1'b0;
        ext_run = 1'b1;
        demand = 8'sd40;
        wait_clk(6 * TEXT);
        measure(TEXT, hi, r);
        check("R7 ext sync high ticks per half cycle", hi, 40);
        measure(2 * TEXT, hi, r);
        check("R7 pulses per sync cycle", r, 2);
        ext_run = 1'b0;
        src_int = 1'b1;

        // R8 shutdown and disable
        step(-20, 1, 108, "R8 setup heat");
        shdn_n = 1'b0;
        wait_clk(2);
        check("R8 shutdown out_en", int'(out_en), 0);
        check("R8 shutdown dir", int'(dir), 0);
        measure(P, hi, r);
        check("R8 shutdown pwm", hi, 0);
        shdn_n = 1'b1;
        wait_clk(1);
        check("R8 restart cleared dir", int'(dir), 0);
        check("R8 restart first period pwm", int'(pwm), 0);
        step(-20, 1, 108, "R8 resumed heat");
        out_dis = 1'b1;
        wait_clk(1);
        check("R8 disable out_en", int'(out_en), 0);
        check("R8 disable dir", int'(dir), 0);
        out_dis = 1'b0;
        wait_clk(2);

        // random demands against the model (model state: cooling after re-enable)
        m_dir = 0;
        step(20, 0, 20, "R1 random prelude");
        for (int k = 0; k < 8; k++) begin
            int d, eh;
            d  = int'($urandom_range(0, 255)) - 128;
            eh = model_hi(d);
            step(d, m_dir, eh, $sformatf("R2 random demand %0d", d));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule